// File: doc/BRIEF.md
# Dual-Buffer Serial Flash Front End

This block is the serial-side front end of a page-organised flash device. It acts as an SPI slave in clock modes 0 and 3, decodes the command byte of each chip-select frame, and serves two on-chip SRAM page buffers and a status byte. The host can fill either buffer from any offset, stream either buffer back from any offset, or poll the status byte while an array engine, outside this block, reports busy.

The buffer size is chosen by the `page264` input: 264 bytes with a 9-bit offset or 256 bytes with an 8-bit offset. Write and read offsets wrap at the end of the selected size. A frame is always cut short by chip select going high, which also releases the data output.

Everything runs on the system clock `clk`. `sck`, `cs_n` and `si` are sampled on it and serial clock edges are found by comparing each sample with the previous one. The state machine has the states `S_OPC` (take the command byte), `S_ADDR` (three address bytes), `S_DUMMY` (one pad byte before read data), `S_WDATA` (store bytes), `S_RDATA` (stream buffer bytes), `S_STAT` (stream status) and `S_SKIP` (unknown command, wait for deselect). Its transitions are:
- `S_OPC` to `S_ADDR` on a buffer read or write command.
- `S_OPC` to `S_STAT` on the status command.
- `S_OPC` to `S_SKIP` on any other byte.
- `S_ADDR` to `S_DUMMY` (read) or to `S_WDATA` (write) after the third address byte.
- `S_DUMMY` to `S_RDATA` after the pad byte.
- Any state back to `S_OPC` while `cs_n` is high.

Top module: `dbf_front`

## Requirements
- R1: Input bits are taken MSB first on the rising edge of `sck`. `so` changes only after a falling edge of `sck`. Both idle levels of `sck` (modes 0 and 3) work.
- R2: Command 0x84 writes buffer A and command 0x87 writes buffer B. Three address bytes follow, then data bytes, which are stored at consecutive offsets.
- R3: The offset is taken from the 24-bit address. With `page264`=1 it is the low 9 bits; with `page264`=0 it is the low 8 bits. All higher address bits are ignored. A start offset beyond the last byte of the buffer is replaced by 0.
- R4: Command 0xD4 reads buffer A and command 0xD6 reads buffer B. After the three address bytes comes one pad byte. Data then leaves MSB first, with the first bit driven after the falling `sck` edge that follows the pad byte, and `so_oe` is high.
- R5: A read passing the last offset (263 or 255) continues at offset 0 without a gap.
- R6: A write passing the last offset continues at offset 0.
- R7: Command 0xD7 streams the status byte repeatedly while `cs_n` stays low. Bit 7 is the inverse of `busy`, bits 5..2 are 1001, bit 0 is 1 in 256-byte mode and 0 in 264-byte mode, and bits 6 and 1 are 0. `busy` is sampled again at each byte boundary.
- R8: `cs_n` high ends any frame, including one cut off mid-byte, and forces `so_oe` low. A partial byte is discarded, and the next frame starts with a command byte.
- R9: An unknown command byte keeps `so_oe` low for the rest of the frame, and any bytes that follow change no buffer.
- R10: A write to one buffer leaves the other buffer unchanged.
- R11: After reset `so_oe` and `so` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | Serial clock from host |
| cs_n | input | 1 | Active-low chip select |
| si | input | 1 | Serial data in |
| page264 | input | 1 | 1: 264-byte buffers, 0: 256-byte buffers |
| busy | input | 1 | Array engine busy flag |
| so | output | 1 | Serial data out |
| so_oe | output | 1 | Output enable for `so` (tristate control) |

## Verification
Two functions can act in the same clock cycle: the `busy` flag from the array engine can change in the very cycle that the status byte is captured at a byte boundary. The bench provokes this by changing `busy` together with the last rising `sck` edge of a status byte. It expects the following status byte to carry the new value, and the byte already on the wire to keep the old one. A second coincidence is the wrap of the buffer offset on the same byte that completes a read or write. Runs that cross offset 263 or 255 are checked byte by byte against a bench model of both buffers.

// File: rtl/dbf_pkg.sv
package dbf_pkg;

    typedef enum logic [2:0] {
        S_OPC,
        S_ADDR,
        S_DUMMY,
        S_WDATA,
        S_RDATA,
        S_STAT,
        S_SKIP
    } fe_state_t;

    localparam logic [7:0] CMD_WR_A = 8'h84;
    localparam logic [7:0] CMD_WR_B = 8'h87;
    localparam logic [7:0] CMD_RD_A = 8'hD4;
    localparam logic [7:0] CMD_RD_B = 8'hD6;
    localparam logic [7:0] CMD_STAT = 8'hD7;

    localparam logic [3:0] DENSITY_CODE = 4'b1001;

endpackage

// File: rtl/dbf_spi_rx.sv
module dbf_spi_rx (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sck,
    input  logic       cs_n,
    input  logic       si,
    output logic       sck_fall,
    output logic       byte_done,
    output logic       bit_zero,
    output logic [7:0] rx_byte
);
    logic       sck_q;
    logic [2:0] bit_cnt;
    logic [6:0] shreg;
    logic       sck_rise;

    assign sck_rise  = !cs_n && sck && !sck_q;
    assign sck_fall  = !cs_n && !sck && sck_q;
    assign byte_done = sck_rise && (bit_cnt == 3'd7);
    assign bit_zero  = (bit_cnt == 3'd0);
    assign rx_byte   = {shreg, si};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_q   <= 1'b0;
            bit_cnt <= '0;
            shreg   <= '0;
        end else begin
            sck_q <= sck;
            if (cs_n) begin
                bit_cnt <= '0;
            end else if (sck_rise) begin
                shreg   <= {shreg[5:0], si};
                bit_cnt <= bit_cnt + 3'd1;
            end
        end
    end

    // R8: a deselect always restarts bit counting
    assert_bit_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> bit_zero);

endmodule

// File: rtl/dbf_page_buf.sv
module dbf_page_buf #(
    parameter int DEPTH = 264,
    parameter int AW    = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [7:0]    wdata,
    output logic [7:0]    rdata
);
    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[addr] <= wdata;
    end

    assign rdata = mem[addr];

    // R6: writes never land beyond the storage
    assert_write_in_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        we |-> (int'(addr) < DEPTH));

endmodule

// File: rtl/dbf_tx.sv
module dbf_tx (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cs_n,
    input  logic       sck_fall,
    input  logic       bit_zero,
    input  logic       active,
    input  logic       load,
    input  logic [7:0] load_byte,
    output logic       so,
    output logic       so_oe
);
    logic [7:0] pending;
    logic [6:0] shreg;
    logic       so_r;
    logic       oe_r;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pending <= '0;
            shreg   <= '0;
            so_r    <= 1'b0;
            oe_r    <= 1'b0;
        end else begin
            if (load) pending <= load_byte;
            if (cs_n) begin
                oe_r <= 1'b0;
            end else if (sck_fall && active) begin
                oe_r <= 1'b1;
                if (bit_zero) begin
                    so_r  <= pending[7];
                    shreg <= pending[6:0];
                end else begin
                    so_r  <= shreg[6];
                    shreg <= {shreg[5:0], 1'b0};
                end
            end
        end
    end

    assign so    = so_r;
    assign so_oe = oe_r && !cs_n;

    // R1: output bit moves only on a registered falling serial edge
    assert_so_on_fall_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !sck_fall |=> $stable(so_r));

endmodule

// File: rtl/dbf_front.sv
module dbf_front #(
    parameter int SMALL_BYTES = 256,
    parameter int LARGE_BYTES = 264
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sck,
    input  logic cs_n,
    input  logic si,
    input  logic page264,
    input  logic busy,
    output logic so,
    output logic so_oe
);
    import dbf_pkg::*;

    localparam int AW   = $clog2(LARGE_BYTES);
    localparam int NBUF = 2;

    fe_state_t        state, nxt;
    logic             sck_fall, byte_done, bit_zero;
    logic [7:0]       rx_byte;
    logic [1:0]       addr_cnt;
    logic             mid_lsb;
    logic             tgt;
    logic             rd_mode;
    logic [AW-1:0]    off, next_off, last_off;
    logic [NBUF-1:0]  we;
    logic [7:0]       rd_byte [NBUF];
    logic             tx_load, tx_active;
    logic [7:0]       tx_byte, status_byte;
    logic             is_buf_cmd;

    dbf_spi_rx u_rx (
        .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .si(si),
        .sck_fall(sck_fall), .byte_done(byte_done), .bit_zero(bit_zero),
        .rx_byte(rx_byte)
    );

    for (genvar g = 0; g < NBUF; g++) begin : g_buf
        dbf_page_buf #(.DEPTH(LARGE_BYTES), .AW(AW)) u_buf (
            .clk(clk), .rst_n(rst_n), .we(we[g]), .addr(off),
            .wdata(rx_byte), .rdata(rd_byte[g])
        );
    end

    dbf_tx u_tx (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck_fall(sck_fall),
        .bit_zero(bit_zero), .active(tx_active), .load(tx_load),
        .load_byte(tx_byte), .so(so), .so_oe(so_oe)
    );

    assign last_off    = page264 ? AW'(LARGE_BYTES - 1) : AW'(SMALL_BYTES - 1);
    assign next_off    = (off >= last_off) ? '0 : off + AW'(1);
    assign status_byte = {~busy, 1'b0, DENSITY_CODE, 1'b0, ~page264};
    assign is_buf_cmd  = (rx_byte == CMD_WR_A) || (rx_byte == CMD_WR_B) ||
                         (rx_byte == CMD_RD_A) || (rx_byte == CMD_RD_B);
    assign tx_active   = (state == S_RDATA) || (state == S_STAT);

    function automatic logic [AW-1:0] start_off(input logic hi, input logic [7:0] lo,
                                                 input logic big, input logic [AW-1:0] last);
        logic [AW-1:0] raw;
        raw = big ? AW'({hi, lo}) : AW'(lo);
        return (raw > last) ? '0 : raw;
    endfunction

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    state <= S_OPC;
        else if (cs_n) state <= S_OPC;
        else           state <= nxt;
    end

    // next state
    always_comb begin
        nxt = state;
        unique case (state)
            S_OPC: if (byte_done) begin
                if (is_buf_cmd)               nxt = S_ADDR;
                else if (rx_byte == CMD_STAT) nxt = S_STAT;
                else                          nxt = S_SKIP;
            end
            S_ADDR:  if (byte_done && addr_cnt == 2'd2) nxt = rd_mode ? S_DUMMY : S_WDATA;
            S_DUMMY: if (byte_done) nxt = S_RDATA;
            S_WDATA, S_RDATA, S_STAT, S_SKIP: nxt = state;
        endcase
    end

    // outputs of the machine
    always_comb begin
        we      = '0;
        tx_load = 1'b0;
        tx_byte = status_byte;
        unique case (state)
            S_OPC:   tx_load = byte_done && (rx_byte == CMD_STAT);
            S_DUMMY, S_RDATA: begin
                tx_load = byte_done;
                tx_byte = rd_byte[tgt];
            end
            S_WDATA: we[tgt] = byte_done;
            S_STAT:  tx_load = byte_done;
            S_ADDR, S_SKIP: ;
        endcase
    end

    // command, address and offset tracking
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_cnt <= '0;
            mid_lsb  <= 1'b0;
            tgt      <= 1'b0;
            rd_mode  <= 1'b0;
            off      <= '0;
        end else if (cs_n) begin
            addr_cnt <= '0;
        end else if (byte_done) begin
            unique case (state)
                S_OPC: begin
                    tgt     <= (rx_byte == CMD_WR_B) || (rx_byte == CMD_RD_B);
                    rd_mode <= (rx_byte == CMD_RD_A) || (rx_byte == CMD_RD_B);
                end
                S_ADDR: begin
                    addr_cnt <= addr_cnt + 2'd1;
                    mid_lsb  <= rx_byte[0];
                    if (addr_cnt == 2'd2) off <= start_off(mid_lsb, rx_byte, page264, last_off);
                end
                S_DUMMY, S_WDATA, S_RDATA: off <= next_off;
                S_STAT, S_SKIP: ;
            endcase
        end
    end

    // R9: an unknown command never enables the output
    assert_skip_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_SKIP) |-> !so_oe);

    // R4: the output is only enabled while streaming read or status data
    assert_oe_when_reading_R4: assert property (@(posedge clk) disable iff (!rst_n)
        so_oe |-> (state == S_RDATA || state == S_STAT));

    // R10: at most one buffer written per cycle
    assert_one_buffer_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(we));

    // R5: the offset stays inside the selected buffer during data phases
    assert_off_in_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_RDATA || state == S_WDATA) |-> (off <= last_off));

    // R6: a byte stored at the last offset moves the offset to 0
    assert_write_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_WDATA && byte_done && off == last_off && !cs_n && $stable(page264))
        |=> (off == '0));

endmodule

// File: tb/dbf_front_test.sv
module dbf_front_test;

    logic clk = 1'b0, rst_n = 1'b0, sck = 1'b0, cs_n = 1'b1, si = 1'b0;
    logic page264 = 1'b1, busy = 1'b0;
    logic so, so_oe;

    int n_chk = 0, n_fail = 0;
    logic [7:0] model [2][264];
    bit busy_arm = 0;
    logic busy_new = 1'b0;

    dbf_front uut (
        .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .si(si),
        .page264(page264), .busy(busy), .so(so), .so_oe(so_oe)
    );

    always #5 clk = ~clk;

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int last_b();
        return page264 ? 263 : 255;
    endfunction

    function automatic int wrap_nx(input int i);
        return (i >= last_b()) ? 0 : i + 1;
    endfunction

    function automatic logic [7:0] exp_status(input logic bz, input logic big);
        return {~bz, 1'b0, 4'b1001, 1'b0, ~big};
    endfunction

    // one byte, MSB first; so sampled after each falling edge, rechecked before the next
    task automatic xfer(input logic [7:0] tx, output logic [7:0] rx,
                        output bit oe_all, output bit oe_any, output bit steady);
        oe_all = 1; oe_any = 0; steady = 1;
        for (int i = 7; i >= 0; i--) begin
            sck = 1'b0; si = tx[i];
            tick(2);
            rx[i] = so; oe_all &= so_oe; oe_any |= so_oe;
            sck = 1'b1;
            if (i == 0 && busy_arm) begin busy = busy_new; busy_arm = 0; end
            tick(2);
            if (so !== rx[i]) steady = 0;
        end
    endtask

    task automatic open_frame(input bit mode3);
        sck = mode3; tick(2); cs_n = 1'b0; tick(2);
    endtask

    task automatic close_frame();
        tick(2); cs_n = 1'b1; tick(3);
        check(so_oe == 1'b0, "R8 oe low after deselect", so_oe, 0);
        sck = 1'b0; tick(2);
    endtask

    task automatic send_addr(input int start);
        logic [7:0] r; bit a, b, c;
        logic [23:0] ad;
        ad = {$urandom(), $urandom()};
        if (page264) ad[8:0] = start[8:0]; else ad[7:0] = start[7:0];
        xfer(ad[23:16], r, a, b, c);
        xfer(ad[15:8], r, a, b, c);
        xfer(ad[7:0], r, a, b, c);
    endtask

    task automatic wr_buf(input int bsel, input int start, input int n, input bit mode3);
        logic [7:0] r, d; bit a, b, c; int idx;
        open_frame(mode3);
        xfer(bsel ? 8'h87 : 8'h84, r, a, b, c);
        send_addr(start);
        idx = (start > last_b()) ? 0 : start;
        for (int k = 0; k < n; k++) begin
            d = 8'($urandom());
            xfer(d, r, a, b, c);
            model[bsel][idx] = d;
            idx = wrap_nx(idx);
        end
        close_frame();
    endtask

    task automatic rd_buf(input int bsel, input int start, input int n, input bit mode3,
                          input string req);
        logic [7:0] r; bit a, b, c; int idx;
        open_frame(mode3);
        xfer(bsel ? 8'hD6 : 8'hD4, r, a, b, c);
        send_addr(start);
        xfer(8'h00, r, a, b, c);
        idx = (start > last_b()) ? 0 : start;
        for (int k = 0; k < n; k++) begin
            xfer(8'h00, r, a, b, c);
            check(r == model[bsel][idx], req, r, model[bsel][idx]);
            check(a && c, {req, " R4/R1 oe+steady"}, {a, c}, 2'b11);
            idx = wrap_nx(idx);
        end
        close_frame();
    endtask

    task automatic rd_status(input int n, input bit mode3);
        logic [7:0] r, e; bit a, b, c; logic bz;
        open_frame(mode3);
        xfer(8'hD7, r, a, b, c);
        for (int k = 0; k < n; k++) begin
            bz = busy;
            if (k == 1) begin busy_new = ~busy; busy_arm = 1; end
            xfer(8'h00, r, a, b, c);
            e = exp_status(bz, page264);
            check(r == e && a, "R7 status byte", r, e);
        end
        close_frame();
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=hung expected=done");
        finish_run();
    end

    initial begin
        logic [7:0] r; bit a, b, c, any;
        void'($urandom(32'd1234));
        tick(3);
        check(so_oe == 1'b0 && so == 1'b0, "R11 reset outputs", {so_oe, so}, 0);
        rst_n = 1'b1; tick(2);

        // fill both buffers, 264-byte mode (R2)
        page264 = 1'b1;
        wr_buf(0, 0, 264, 0);
        wr_buf(1, 0, 264, 0);
        rd_buf(0, 0, 6, 0, "R2 buffer A contents");
        rd_buf(1, 0, 6, 0, "R2 buffer B contents");
        rd_buf(0, 259, 10, 0, "R5 read wrap at 263");

        // 256-byte mode write wrap and read wrap (R3, R5, R6)
        page264 = 1'b0;
        wr_buf(1, 250, 10, 0);
        rd_buf(1, 250, 12, 0, "R6 write wrap at 255");
        rd_buf(0, 253, 5, 0, "R10 buffer A untouched");

        // start offset beyond the last byte (R3)
        page264 = 1'b1;
        rd_buf(1, 300, 4, 0, "R3 start beyond end");

        // unknown command (R9)
        open_frame(0);
        xfer(8'h3C, r, a, b, c);
        any = b;
        for (int k = 0; k < 8; k++) begin
            xfer(8'($urandom()), r, a, b, c);
            any |= b;
        end
        check(!any, "R9 unknown command keeps oe low", any, 0);
        close_frame();
        rd_buf(0, 0, 8, 0, "R9 buffers unchanged");
        rd_buf(1, 0, 8, 0, "R9 buffers unchanged");

        // frame cut mid-byte (R8)
        open_frame(0);
        xfer(8'h87, r, a, b, c);
        send_addr(20);
        xfer(8'hA5, r, a, b, c);
        model[1][20] = 8'hA5;
        for (int i = 0; i < 4; i++) begin
            sck = 1'b0; si = 1'b1; tick(2); sck = 1'b1; tick(2);
        end
        close_frame();
        rd_buf(1, 19, 4, 0, "R8 partial byte dropped");

        // mode 3 (R1)
        wr_buf(0, 100, 8, 1);
        rd_buf(0, 98, 12, 1, "R1 mode 3 transfer");

        // status with busy flipping at a byte boundary (R7)
        busy = 1'b0; page264 = 1'b1;
        rd_status(4, 0);
        busy = 1'b1; page264 = 1'b0;
        rd_status(4, 1);
        busy = 1'b0;

        // constrained random mix
        for (int it = 0; it < 30; it++) begin
            int bs, st, n;
            page264 = 1'($urandom());
            bs = int'($urandom() % 2);
            st = int'($urandom() % (last_b() + 1));
            n  = 1 + int'($urandom() % 16);
            if ($urandom() % 2 == 1) wr_buf(bs, st, n, 1'($urandom()));
            rd_buf(bs, st, n + 2, 1'($urandom()), "R2/R5 random read-back");
        end

        finish_run();
    end

endmodule